// File: doc/BRIEF.md
# Byte-Wide Interrupt Controller Front End

This block gathers eight interrupt sources into one level output for a system interrupt aggregator. Each source is latched in a pending register. External logic can set pending bits with a post strobe vector and remove them with a clear strobe vector. Software reaches the block through a byte-wide register port with a two-bit address. Through that port it can program an enable mask, acknowledge one source at a time, and read the pending bits.

The mask is kept internally as an enable vector, which is the bitwise inverse of the written byte, so a written 1 blocks that source. The output follows an edge-tracked policy. The events that change it are a post strobe, a mask write, an acknowledge or a clear strobe, and each event has its own rule. Nothing re-evaluates the output on every cycle. A second controller is present in the address map only. Writes to it are accepted and have no effect, and reads from it return zero. Priority resolution, vector generation and the initialisation command sequence are not part of the block.

Address map: 0 = primary status (read) / acknowledge command (write), 1 = primary mask, 2 = secondary status/command, 3 = secondary mask.

Top module: `pic_fe`

## Requirements
- R1: After reset is asserted (rst_ni low, asynchronous), irq_o is 0. The pending register reads 0x00 at address 0, and the mask reads 0xFF at address 1 because the enable vector is all zeros.
- R2: A write to address 1 stores the inverse of wdata_i as the enable vector. Reading address 1 afterwards returns the written byte.
- R3: When a write to address 1 leaves at least one pending source enabled, irq_o is 1 in the cycle after the write edge.
- R4: When a write to address 1 leaves no pending source enabled, irq_o is 0 in the cycle after the write edge.
- R5: A write to address 0 clears the pending bit whose index is wdata_i[3:0] and ignores wdata_i[7:4]. irq_o is 0 after that edge, even if other enabled bits are still pending.
- R6: An acknowledge index of 8 to 15 leaves the pending register unchanged, and irq_o still drops.
- R7: rdata_o is combinational on addr_i. Address 0 returns the pending register. Addresses 2 and 3 always return 0x00.
- R8: Writes to address 2 or 3 change neither irq_o nor the pending register.
- R9: A nonzero post_i ORs its bits into the pending register and sets irq_o to 1 after the edge, whatever the enable vector holds.
- R10: clr_i clears its bits from the pending register. irq_o drops after the edge only if no enabled pending bit remains; otherwise it holds.
- R11: When events coincide in one cycle, post_i wins over clr_i for the same bit, and an acknowledge wins over a post for irq_o (irq_o goes to 0). The acknowledge still clears its bit from the merged pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| post_i | input | 8 | Per-source set strobes |
| clr_i | input | 8 | Per-source clear strobes |
| irq_o | output | 1 | Level interrupt toward the aggregator |

## Verification
The bench targets the places where the output policy departs from a plain "any enabled pending" level:
- A post to a masked source must still raise the output. A design that gates posts with the enable vector would stay low.
- An acknowledge must drop the output even while other enabled bits are pending. A level-recomputing design would keep it high.
- A clear strobe that leaves one enabled bit pending must hold the output. A design that drops it on every clear would fall too early.

Coincident post and clear on the same bit, an acknowledge together with a post, acknowledge indices above 7 and a high nibble of data that must be ignored each catch a wrong merge order or a decoder that uses the wrong slice. Secondary-controller writes are checked against both the output and the pending readback.

// File: rtl/pic_fe_pkg.sv
package pic_fe_pkg;
  localparam int IDX_W = 4;  // acknowledge index taken from low nibble

  typedef enum logic [1:0] {
    REG_PRI_STAT = 2'd0,
    REG_PRI_MASK = 2'd1,
    REG_SEC_STAT = 2'd2,
    REG_SEC_MASK = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ack;
    logic pri_mask;
  } wr_strb_t;
endpackage

// File: rtl/pic_fe_decode.sv
module pic_fe_decode
  import pic_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] pend_i,
  input  logic [DATA_W-1:0] en_i,
  output wr_strb_t          strb_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    strb_o          = '0;
    strb_o.ack      = wr_en_i && (sel == REG_PRI_STAT);
    strb_o.pri_mask = wr_en_i && (sel == REG_PRI_MASK);
  end

  always_comb begin
    unique case (sel)
      REG_PRI_STAT: rdata_o = pend_i;
      REG_PRI_MASK: rdata_o = ~en_i;
      default:      rdata_o = '0;  // secondary controller reads as zero
    endcase
  end
endmodule

// File: rtl/pic_fe_pending.sv
module pic_fe_pending
  import pic_fe_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] post_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic [NUM_SRC-1:0] pend_q_o,
  output logic [NUM_SRC-1:0] pend_d_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic ack_hit;
    assign ack_hit     = ack_i && (ack_idx_i == IDX_W'(i));
    // clear first, post overrides, acknowledge applied last
    assign pend_d_o[i] = ((pend_q[i] & ~clr_i[i]) | post_i[i]) & ~ack_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d_o;
  end

  assign pend_q_o = pend_q;
endmodule

// File: rtl/pic_fe_irq_track.sv
module pic_fe_irq_track #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_d_i,
  input  logic [NUM_SRC-1:0] en_d_i,
  input  logic               ack_i,
  input  logic               mask_wr_i,
  input  logic               post_any_i,
  input  logic               clr_any_i,
  output logic               irq_o
);
  logic irq_q, irq_d, live;

  assign live = |(pend_d_i & en_d_i);

  always_comb begin
    irq_d = irq_q;
    if (ack_i)                  irq_d = 1'b0;
    else if (post_any_i)        irq_d = 1'b1;
    else if (mask_wr_i)         irq_d = live;
    else if (clr_any_i && !live) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pic_fe.sv
module pic_fe
  import pic_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] post_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic              irq_o
);
  localparam int NUM_SRC = DATA_W;

  wr_strb_t           strb;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] pend_q, pend_d;

  assign en_d = strb.pri_mask ? ~wdata_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  pic_fe_decode #(.DATA_W(DATA_W)) u_decode (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .pend_i  (pend_q),
    .en_i    (en_q),
    .strb_o  (strb),
    .rdata_o (rdata_o)
  );

  pic_fe_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .post_i    (post_i),
    .clr_i     (clr_i),
    .ack_i     (strb.ack),
    .ack_idx_i (wdata_i[IDX_W-1:0]),
    .pend_q_o  (pend_q),
    .pend_d_o  (pend_d)
  );

  pic_fe_irq_track #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_d_i   (pend_d),
    .en_d_i     (en_d),
    .ack_i      (strb.ack),
    .mask_wr_i  (strb.pri_mask),
    .post_any_i (|post_i),
    .clr_any_i  (|clr_i),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/pic_fe_checker.sv
module pic_fe_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] post_i,
  input logic [DATA_W-1:0] clr_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] pend_q
);
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> !irq_o);  // R5

  AST_POST_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((post_i != '0) && !(wr_en_i && addr_i == 2'd0)) |=> irq_o);  // R9

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((post_i != '0) || (wr_en_i && addr_i == 2'd1)));  // R3

  AST_SEC_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1] && post_i == '0 && clr_i == '0)
      |=> ($stable(irq_o) && $stable(pend_q)));  // R8

  AST_CLR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~post_i) != '0) |=> ((pend_q & $past(clr_i & ~post_i)) == '0));  // R10

  AST_SEC_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[1] |-> (rdata_o == '0));  // R7

  AST_MASK_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (addr_i != 2'd1 || rdata_o == $past(wdata_i)));  // R2
endmodule

bind pic_fe pic_fe_checker #(.DATA_W(DATA_W)) u_pic_fe_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .post_i  (post_i),
  .clr_i   (clr_i),
  .irq_o   (irq_o),
  .pend_q  (pend_q)
);

// File: tb/pic_fe_bench.sv
`timescale 1ns/1ps
module pic_fe_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] post_i = 8'h00;
  logic [7:0] clr_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pic_fe u_pic_fe (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .rdata_o, .post_i, .clr_i, .irq_o
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] post;
    logic [7:0] clr;
    logic       exp_irq;
    logic [7:0] exp_pend;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 8'h00, 8'h05, 8'h00, 1'b1, 8'h05},  // R9 post while all disabled
    '{1'b1, 2'd1, 8'hFF, 8'h00, 8'h00, 1'b0, 8'h05},  // R4
    '{1'b1, 2'd1, 8'hFE, 8'h00, 8'h00, 1'b1, 8'h05},  // R3
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'h04, 1'b1, 8'h01},  // R10 enabled bit remains
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'h01, 1'b0, 8'h00},  // R10 last enabled bit gone
    '{1'b0, 2'd0, 8'h00, 8'h30, 8'h00, 1'b1, 8'h30},  // R9
    '{1'b1, 2'd0, 8'h04, 8'h00, 8'h00, 1'b0, 8'h20},  // R5
    '{1'b1, 2'd0, 8'h0C, 8'h00, 8'h00, 1'b0, 8'h20},  // R6
    '{1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h20},  // R8
    '{1'b1, 2'd1, 8'hDF, 8'h00, 8'h00, 1'b1, 8'h20},  // R3
    '{1'b1, 2'd3, 8'hFF, 8'h00, 8'h00, 1'b1, 8'h20},  // R8
    '{1'b1, 2'd2, 8'h05, 8'h00, 8'h00, 1'b1, 8'h20},  // R8
    '{1'b1, 2'd0, 8'hF5, 8'h00, 8'h00, 1'b0, 8'h00},  // R5 high nibble ignored
    '{1'b0, 2'd0, 8'h00, 8'h02, 8'h02, 1'b1, 8'h02},  // R11 post beats clear
    '{1'b1, 2'd0, 8'h01, 8'h80, 8'h00, 1'b0, 8'h80},  // R11 ack beats post
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'h80, 1'b0, 8'h00}   // R10
  };

  function automatic string vtag(int k);
    case (k)
      0, 5:         return "R9";
      1:            return "R4";
      2, 9:         return "R3";
      3, 4, 15:     return "R10";
      6, 12:        return "R5";
      7:            return "R6";
      8, 10, 11:    return "R8";
      default:      return "R11";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [1:0] a, logic [7:0] d, logic [7:0] p, logic [7:0] c);
    @(negedge clk_i);
    wr_en_i = wr; addr_i = a; wdata_i = d; post_i = p; clr_i = c;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00; post_i = 8'h00; clr_i = 8'h00;
    #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
    addr_i = 2'd0;
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [7:0] v;
    #5;
    // R1 reset state
    rd(2'd0, v); chk("R1", "pending", v, 8'h00);
    rd(2'd1, v); chk("R1", "mask", v, 8'hFF);
    chk("R1", "irq", {7'd0, irq_o}, 8'h00);
    rd(2'd2, v); chk("R7", "sec stat", v, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].wr, VEC[k].addr, VEC[k].wdata, VEC[k].post, VEC[k].clr);
      chk(vtag(k), $sformatf("vec %0d irq", k), {7'd0, irq_o}, {7'd0, VEC[k].exp_irq});
      rd(2'd0, v);
      chk(vtag(k), $sformatf("vec %0d pending", k), v, VEC[k].exp_pend);
    end

    // R2 mask readback
    step(1'b1, 2'd1, 8'h5A, 8'h00, 8'h00);
    rd(2'd1, v); chk("R2", "mask readback", v, 8'h5A);

    // R7 secondary reads zero with pending nonzero
    step(1'b0, 2'd0, 8'h00, 8'hC3, 8'h00);
    rd(2'd0, v); chk("R7", "pri stat", v, 8'hC3);
    rd(2'd2, v); chk("R7", "sec stat", v, 8'h00);
    rd(2'd3, v); chk("R7", "sec mask", v, 8'h00);

    // R1 asynchronous reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    #2;
    chk("R1", "irq after reset", {7'd0, irq_o}, 8'h00);
    rd(2'd0, v); chk("R1", "pending after reset", v, 8'h00);
    rd(2'd1, v); chk("R1", "mask after reset", v, 8'hFF);
    @(negedge clk_i); rst_ni = 1'b1;

    // R5 acknowledge drops output while another enabled bit pends
    step(1'b1, 2'd1, 8'h00, 8'h00, 8'h00);
    step(1'b0, 2'd0, 8'h00, 8'h03, 8'h00);
    chk("R9", "irq after post", {7'd0, irq_o}, 8'h01);
    step(1'b1, 2'd0, 8'h00, 8'h00, 8'h00);
    chk("R5", "irq after ack", {7'd0, irq_o}, 8'h00);
    rd(2'd0, v); chk("R5", "pending after ack", v, 8'h02);

    // R3 mask rewrite re-raises from remaining pending bit
    step(1'b1, 2'd1, 8'h00, 8'h00, 8'h00);
    chk("R3", "irq after mask rewrite", {7'd0, irq_o}, 8'h01);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule